// File: doc/BRIEF.md
# GPIO Port Controller With One-Shot Output Style

This block manages one general-purpose I/O port of up to eight pins. For each pin it keeps a direction bit, an output value, a polarity inversion bit, an output style bit (steady level or timed one-shot) and a driver type bit (open-drain or push-pull). From these it derives the pad output enable and pad data for every pin. It also presents the synchronised pin levels for reading. An internal register bus with a write strobe, a shared address and a combinational read port reaches all of this state.

In one-shot style, writing 1 to a pin's output bit raises that bit for a fixed number of clock cycles. The bit then clears itself, so a later write of 1 starts a new shot. Polarity inversion is applied after the output bit, so an inverted pin gives a low-going shot. Open-drain pins pull low only while the pin value is 0 and float otherwise.

While either reset pin is low, the block latches the raw pin levels into a strap register. Three of the latched pins form the low bits of a 7-bit bus address of the form 0011xxx. The power-on reset clears the port registers every time. The external reset clears them only when the keep input is low. The keep input comes from a global register that the external reset does not touch.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset the direction register (bus address 3) reads all ones. A direction bit of 1 makes the pin an input, with pad_oe low and pad_do low for that pin.
- R2: A pin in level style (style bit 0) with direction 0 holds the value last written to the output register (address 1) until the next write. Push-pull pins (drive bit 1) drive pad_oe high and pad_do equal to the pin value.
- R3: An open-drain pin (drive bit 0) with direction 0 raises pad_oe only while its pin value is 0 and keeps pad_do low at all times.
- R4: For a pin in one-shot style (style register at address 4, bit 1), writing 1 to its output bit holds the bit high for exactly PULSE_CYCLES clock cycles. The bit then clears by itself and reads back 0. A new write of 1 restarts the full width.
- R5: The pin value is the output bit XOR the inversion bit (address 2), so an inverted one-shot pin idles high and pulses low.
- R6: After reset the output, inversion, style and drive (address 5) registers read 0, and unmapped address 7 reads 0.
- R7: Address 0 returns the pin levels through a SYNC_STAGES-flop synchroniser: a pin change appears on a read after exactly SYNC_STAGES clock edges.
- R8: While rst_n or ext_rst_n is low, the strap register (address 6) captures the raw pin levels every cycle. It holds them once both resets are high. smb_addr equals {0011, pin STRAP_LO, pin STRAP_LO+1, pin STRAP_LO+2} of the latched value.
- R9: ext_rst_n low clears the port registers only while keep_cfg is 0. rst_n low clears them regardless of keep_cfg.
- R10: Writing 0 to an output bit during a one-shot ends the shot at once: the bit reads 0 from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-on reset, active low, synchronous |
| ext_rst_n | input | 1 | External reset pin, active low, synchronous |
| keep_cfg | input | 1 | When 1, ext_rst_n does not clear the port registers |
| bus_addr | input | 3 | Register address for reads and writes |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data for bus_addr (combinational) |
| pad_in | input | WIDTH | Pin levels from the pads |
| pad_oe | output | WIDTH | Pad output enable per pin |
| pad_do | output | WIDTH | Pad output data per pin |
| smb_addr | output | 7 | Bus address formed from strapped pins |

## Verification
The bench times one-shots edge by edge, including a pin with inverted polarity. A counter that is off by one would show the pin still active, or already idle, at the cycle either side of PULSE_CYCLES. Retriggering part way through a shot and cancelling with a write of 0 expose a design that ignores writes while busy. Open-drain pins driving 1 check that the pad never drives high. The synchroniser depth is checked by sampling one edge early. The mask test resets with keep_cfg high and low. A design that ignores keep_cfg would lose written state, and one that lets keep_cfg block the power-on reset would keep it.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

   localparam int unsigned REG_AW = 3;

   typedef enum logic [REG_AW-1:0] {
      RA_PIN   = 3'd0,
      RA_OUT   = 3'd1,
      RA_INV   = 3'd2,
      RA_DIR   = 3'd3,
      RA_STYLE = 3'd4,
      RA_DRIVE = 3'd5,
      RA_STRAP = 3'd6
   } reg_addr_e;

   localparam logic [3:0] BUS_ADDR_HI = 4'b0011;

endpackage

// File: rtl/gpio_out_bit.sv
module gpio_out_bit #(
   parameter int unsigned PULSE_CYCLES = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic wr,
   input  logic wval,
   input  logic pulse_style,
   output logic q
);
   localparam int unsigned CNT_W = $clog2(PULSE_CYCLES + 1);
   localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_CYCLES);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (clr) begin
         q   <= 1'b0;
         cnt <= '0;
      end else if (wr) begin
         q   <= wval;
         cnt <= (pulse_style && wval) ? LOAD : '0;
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
         if (cnt == LAST) q <= 1'b0;
      end
   end

   // R4: a write of 1 in one-shot style arms the full width
   p_pulse_arm_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && wr && wval && pulse_style) |=> (q && cnt == LOAD));
   // R4: the last count drops the bit
   p_pulse_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !wr && cnt == LAST) |=> !q);
   // R10: writing 0 ends any shot
   p_cancel_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && wr && !wval) |=> (!q && cnt == '0));
   // R2: level style without a write keeps its value
   p_level_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !wr && cnt == '0) |=> $stable(q));

endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux (
   input  logic is_input,
   input  logic push_pull,
   input  logic value,
   output logic oe,
   output logic dout
);
   always_comb begin
      if (is_input) begin
         oe   = 1'b0;
         dout = 1'b0;
      end else if (push_pull) begin
         oe   = 1'b1;
         dout = value;
      end else begin
         oe   = ~value;
         dout = 1'b0;
      end
   end
endmodule

// File: rtl/gpio_strap_latch.sv
module gpio_strap_latch #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ext_rst_n,
   input  logic [WIDTH-1:0] pins,
   output logic [WIDTH-1:0] strap
);
   always_ff @(posedge clk) begin
      if (!rst_n || !ext_rst_n) strap <= pins;
   end

   // R8: outside reset the captured levels do not move
   p_strap_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && ext_rst_n) |=> $stable(strap));
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
   import gpio_port_pkg::*;
#(
   parameter int unsigned WIDTH        = 8,
   parameter int unsigned PULSE_CYCLES = 50,
   parameter int unsigned SYNC_STAGES  = 2,
   parameter int unsigned STRAP_LO     = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ext_rst_n,
   input  logic              keep_cfg,
   input  logic [REG_AW-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [WIDTH-1:0]  bus_wdata,
   output logic [WIDTH-1:0]  bus_rdata,
   input  logic [WIDTH-1:0]  pad_in,
   output logic [WIDTH-1:0]  pad_oe,
   output logic [WIDTH-1:0]  pad_do,
   output logic [6:0]        smb_addr
);
   initial begin
      assert (WIDTH >= 1 && WIDTH <= 8) else $fatal(1, "WIDTH must be 1..8");
      assert (PULSE_CYCLES >= 1) else $fatal(1, "PULSE_CYCLES must be >= 1");
      assert (STRAP_LO + 3 <= WIDTH) else $fatal(1, "strap pins exceed port");
   end

   logic             port_clr;
   logic [WIDTH-1:0] dir_q, inv_q, style_q, drive_q, out_q;
   logic [WIDTH-1:0] pin_seen, strap_q, pin_val;
   logic             wr_out, wr_inv, wr_dir, wr_style, wr_drive;

   assign port_clr = !rst_n || (!ext_rst_n && !keep_cfg);

   assign wr_out   = bus_wr && (bus_addr == RA_OUT);
   assign wr_inv   = bus_wr && (bus_addr == RA_INV);
   assign wr_dir   = bus_wr && (bus_addr == RA_DIR);
   assign wr_style = bus_wr && (bus_addr == RA_STYLE);
   assign wr_drive = bus_wr && (bus_addr == RA_DRIVE);

   always_ff @(posedge clk) begin
      if (port_clr) begin
         dir_q   <= '1;
         inv_q   <= '0;
         style_q <= '0;
         drive_q <= '0;
      end else begin
         if (wr_dir)   dir_q   <= bus_wdata;
         if (wr_inv)   inv_q   <= bus_wdata;
         if (wr_style) style_q <= bus_wdata;
         if (wr_drive) drive_q <= bus_wdata;
      end
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      gpio_out_bit #(.PULSE_CYCLES(PULSE_CYCLES)) u_out (
         .clk        (clk),
         .rst_n      (rst_n),
         .clr        (port_clr),
         .wr         (wr_out),
         .wval       (bus_wdata[i]),
         .pulse_style(style_q[i]),
         .q          (out_q[i])
      );

      assign pin_val[i] = out_q[i] ^ inv_q[i];

      gpio_pad_mux u_pad (
         .is_input (dir_q[i]),
         .push_pull(drive_q[i]),
         .value    (pin_val[i]),
         .oe       (pad_oe[i]),
         .dout     (pad_do[i])
      );
   end

   if (SYNC_STAGES == 0) begin : g_nosync
      assign pin_seen = pad_in;
   end else begin : g_sync
      logic [WIDTH-1:0] stage_q [SYNC_STAGES];
      always_ff @(posedge clk) begin
         stage_q[0] <= pad_in;
         for (int s = 1; s < SYNC_STAGES; s++) stage_q[s] <= stage_q[s-1];
      end
      assign pin_seen = stage_q[SYNC_STAGES-1];
   end

   gpio_strap_latch #(.WIDTH(WIDTH)) u_strap (
      .clk      (clk),
      .rst_n    (rst_n),
      .ext_rst_n(ext_rst_n),
      .pins     (pad_in),
      .strap    (strap_q)
   );

   assign smb_addr = {BUS_ADDR_HI, strap_q[STRAP_LO], strap_q[STRAP_LO+1],
                      strap_q[STRAP_LO+2]};

   always_comb begin
      case (reg_addr_e'(bus_addr))
         RA_PIN:   bus_rdata = pin_seen;
         RA_OUT:   bus_rdata = out_q;
         RA_INV:   bus_rdata = inv_q;
         RA_DIR:   bus_rdata = dir_q;
         RA_STYLE: bus_rdata = style_q;
         RA_DRIVE: bus_rdata = drive_q;
         RA_STRAP: bus_rdata = strap_q;
         default:  bus_rdata = '0;
      endcase
   end

   // R1: reset leaves every pin an input
   p_dir_reset_r1: assert property (@(posedge clk)
      !rst_n |=> (dir_q == '1));
   // R1: setting all direction bits releases every pad
   p_input_float_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!port_clr && wr_dir && bus_wdata == '1) |=> (pad_oe == '0));
   // R3: an open-drain pad never drives a high level
   p_od_low_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_oe & pad_do & ~drive_q) == '0));
   // R9: a masked external reset leaves configuration untouched
   p_mask_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!ext_rst_n && keep_cfg && !bus_wr) |=>
      ($stable(dir_q) && $stable(inv_q) && $stable(style_q) && $stable(drive_q)));

endmodule

// File: tb/gpio_port_ctrl_bench.sv
module gpio_port_ctrl_bench;
   localparam int W = 8;
   localparam int P = 50;
   localparam int S = 2;

   logic         clk = 1'b0;
   logic         rst_n, ext_rst_n, keep_cfg, bus_wr;
   logic [2:0]   bus_addr;
   logic [W-1:0] bus_wdata, bus_rdata, pad_in, pad_oe, pad_do;
   logic [6:0]   smb_addr;

   int checks = 0;
   int failures = 0;

   always #5 clk = ~clk;

   gpio_port_ctrl #(.WIDTH(W), .PULSE_CYCLES(P), .SYNC_STAGES(S), .STRAP_LO(5))
   u_gpio_port_ctrl (
      .clk(clk), .rst_n(rst_n), .ext_rst_n(ext_rst_n), .keep_cfg(keep_cfg),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_oe(pad_oe),
      .pad_do(pad_do), .smb_addr(smb_addr)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [2:0] a, input logic [W-1:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [2:0] a, output logic [W-1:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic t_reset_state;
      logic [W-1:0] v;
      rd_reg(3, v); chk("R1 dir reset", v, 8'hFF);
      chk("R1 pads float", pad_oe, 8'h00);
      chk("R1 pad data low", pad_do, 8'h00);
      rd_reg(1, v); chk("R6 out reset", v, 8'h00);
      rd_reg(2, v); chk("R6 inv reset", v, 8'h00);
      rd_reg(4, v); chk("R6 style reset", v, 8'h00);
      rd_reg(5, v); chk("R6 drive reset", v, 8'h00);
      rd_reg(7, v); chk("R6 unmapped", v, 8'h00);
      rd_reg(6, v); chk("R8 strap value", v, 8'hA0);
      chk("R8 strap address", smb_addr, 7'h1D);
   endtask

   task automatic t_level_pp;
      logic [W-1:0] v;
      wr_reg(5, 8'hFF);
      wr_reg(3, 8'h00);
      wr_reg(2, 8'h0F);
      wr_reg(1, 8'h3C);
      chk("R2 pp enable", pad_oe, 8'hFF);
      chk("R5 pp data inverted", pad_do, 8'h33);
      repeat (10) @(negedge clk);
      chk("R2 level held", pad_do, 8'h33);
      rd_reg(1, v); chk("R2 out readback", v, 8'h3C);
   endtask

   task automatic t_open_drain;
      wr_reg(2, 8'h00);
      wr_reg(5, 8'h00);
      wr_reg(3, 8'hF0);
      wr_reg(1, 8'h05);
      chk("R3 od enable", pad_oe, 8'h0A);
      chk("R3 od data", pad_do, 8'h00);
      wr_reg(3, 8'hFF);
      chk("R1 input after set", pad_oe, 8'h00);
   endtask

   task automatic t_pulse;
      logic [W-1:0] v;
      wr_reg(1, 8'h00);
      wr_reg(5, 8'hFF);
      wr_reg(3, 8'h00);
      wr_reg(2, 8'h02);
      wr_reg(4, 8'h03);
      chk("R5 idle inverted", pad_do[1:0], 2'b10);
      wr_reg(1, 8'h03);
      chk("R4 shot start", pad_do[1:0], 2'b01);
      repeat (P-1) @(negedge clk);
      chk("R4 shot last cycle", pad_do[1:0], 2'b01);
      @(negedge clk);
      chk("R4 shot ended", pad_do[1:0], 2'b10);
      rd_reg(1, v); chk("R4 auto clear", v, 8'h00);
      wr_reg(1, 8'h01);
      repeat (20) @(negedge clk);
      wr_reg(1, 8'h01);
      repeat (P-1) @(negedge clk);
      chk("R4 retrigger held", pad_do[0], 1'b1);
      @(negedge clk);
      chk("R4 retrigger ended", pad_do[0], 1'b0);
   endtask

   task automatic t_cancel;
      logic [W-1:0] v;
      wr_reg(1, 8'h01);
      repeat (5) @(negedge clk);
      chk("R10 shot running", pad_do[0], 1'b1);
      wr_reg(1, 8'h00);
      chk("R10 cancelled pin", pad_do[0], 1'b0);
      rd_reg(1, v); chk("R10 cancelled readback", v, 8'h00);
      repeat (P) @(negedge clk);
      chk("R10 stays low", pad_do[0], 1'b0);
   endtask

   task automatic t_input_sync;
      logic [W-1:0] v;
      @(negedge clk); pad_in = 8'h5A;
      @(negedge clk);
      rd_reg(0, v); chk("R7 one edge early", v, 8'h00);
      @(negedge clk);
      rd_reg(0, v); chk("R7 after sync", v, 8'h5A);
      pad_in = 8'h00;
      repeat (3) @(negedge clk);
   endtask

   task automatic t_reset_mask;
      logic [W-1:0] v;
      wr_reg(2, 8'h0F);
      wr_reg(3, 8'h3C);
      keep_cfg = 1'b1;
      @(negedge clk); ext_rst_n = 1'b0;
      repeat (2) @(negedge clk); ext_rst_n = 1'b1;
      rd_reg(2, v); chk("R9 masked inv kept", v, 8'h0F);
      rd_reg(3, v); chk("R9 masked dir kept", v, 8'h3C);
      rd_reg(6, v); chk("R8 recapture on ext reset", v, 8'h00);
      chk("R8 address after recapture", smb_addr, 7'h18);
      keep_cfg = 1'b0;
      @(negedge clk); ext_rst_n = 1'b0;
      repeat (2) @(negedge clk); ext_rst_n = 1'b1;
      rd_reg(2, v); chk("R9 unmasked inv cleared", v, 8'h00);
      rd_reg(3, v); chk("R9 unmasked dir set", v, 8'hFF);
      wr_reg(2, 8'h0F);
      keep_cfg = 1'b1;
      @(negedge clk); rst_n = 1'b0; pad_in = 8'hE0;
      repeat (2) @(negedge clk); rst_n = 1'b1; pad_in = 8'h00;
      rd_reg(2, v); chk("R9 power-on ignores keep", v, 8'h00);
      chk("R8 address all ones", smb_addr, 7'h1F);
   endtask

   task automatic finish_run;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      rst_n = 1'b0; ext_rst_n = 1'b1; keep_cfg = 1'b0;
      bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0; pad_in = 8'hA0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1; pad_in = 8'h00;
      @(negedge clk);
      t_reset_state();
      t_level_pp();
      t_open_drain();
      t_pulse();
      t_cancel();
      t_input_sync();
      t_reset_mask();
      finish_run();
   end

   initial begin
      #2_000_000;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      finish_run();
   end
endmodule